// File: doc/BRIEF.md
# Multiplexed Common I/O Pin Unit

This block is a general-purpose I/O unit with 22 pins. The pins sit in three groups of eight bit positions: pins 10–17, pins 20–25 and pins 30–37. Pin N is at group (N/10 − 1) and bit (N mod 10). Each pin has a small configuration byte that sets its direction and its polarity, and that can hand the pad to an alternate peripheral. Pins 20–24 are dedicated GPIO pins. The other 17 pins share their pads with a peripheral, which appears here only as plain alternate output, output-enable and input signals.

Configuration bytes and one control byte are reached through a configuration port with byte addresses. Pin levels are read and written through a second pair of host I/O addresses: an index register and a data register. The control byte moves this pair to one of four locations and can switch it off. A host first writes a group number to the index address. It then reads or writes that group's eight pin bits at the data address, which sits one above the index address.

Top module: `cio_unit`

## Requirements
- R1: After a synchronous reset, every pin is an input (`pad_oe` all 0). Every configuration byte reads 0x01, the control byte reads 0x00, all output latches are 0, and the index register is 0.
- R2: In a configuration byte, bit 0 = 1 makes the pin an input, bit 1 = 1 inverts it, and bit 3 = 1 selects the alternate function. Only these three bits are stored. The other bits read back as 0.
- R3: Configuration bytes sit at 0xE0–0xE7 for pins 10–17, at 0xE8–0xED for pins 20–25 and at 0xF5–0xFC for pins 30–37, in ascending pin order. Any other address except 0x03 reads 0, and writes to it change nothing.
- R4: The control byte is at configuration address 0x03. Bit 7 enables the index/data pair. Bits 1–0 put the index address at 0xE0, 0xE2, 0xE4 or 0xEA (select value 0 to 3), with the data address one above. The control byte reads back as {bit7, 00000, bits1–0}.
- R5: While the enable bit is clear, the pair does not respond: `io_hit` stays 0, `io_rdata` is 0, and writes change neither the index nor the output latches.
- R6: Writing the index address loads the index, and reading the index address returns it. Index 1, 2 and 3 select pins 10–17, 20–25 and 30–37 at the data address, with bit position = pin mod 10. Any other index reads 0, and writes through it are ignored.
- R7: A GPIO output pin (bit 0 = 0, bit 3 = 0) drives `pad_oe` = 1 and `pad_out` = latch XOR the invert bit.
- R8: A data read returns pad level XOR the invert bit for input and alternate-mode pins, and the latched value for output pins. Bits 7–6 of group 2 (pins 26 and 27 do not exist) read 0.
- R9: In alternate mode, `pad_out` and `pad_oe` follow `alt_out` and `alt_oe` without inversion, and the output latch has no effect on the pad.
- R10: On the dedicated pins 20–24, configuration bit 3 is not stored: it reads back 0 and the pin stays under GPIO control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for cfg_addr (combinational) |
| io_addr | input | 8 | Host I/O address |
| io_wr | input | 1 | Host I/O write strobe |
| io_rd | input | 1 | Host I/O read strobe |
| io_wdata | input | 8 | Host I/O write data |
| io_rdata | output | 8 | Host I/O read data, 0 unless a read hits the pair |
| io_hit | output | 1 | Pair decodes the current access |
| pad_in | input | 24 | Pad levels, bit = group*8 + (pin mod 10) |
| pad_out | output | 24 | Pad output values |
| pad_oe | output | 24 | Pad output enables |
| alt_out | input | 24 | Alternate peripheral output values |
| alt_oe | input | 24 | Alternate peripheral output enables |
| alt_in | output | 24 | Raw pad levels passed to the alternate peripheral |

## Verification
The assertions check four properties on every cycle: the state seen on the first cycle after reset; that the latches and the index stay unchanged while the pair is off; that the index loads on an index write; and that pad outputs track the latch in output mode but hold steady in alternate mode while the peripheral is quiet. They also check that the dedicated pins' output enables move only after configuration writes. The address map, the read composition with polarity and unused-bit masking, the relocation of the pair and the dropped alternate bit on dedicated pins are shown only by the bench's scenarios, which compare readback and pad values against hand-computed bytes.

// File: rtl/cio_pkg.sv
package cio_pkg;

    localparam int GRP_N = 3;
    localparam int GRP_W = 8;
    localparam int PIN_N = GRP_N * GRP_W;

    localparam logic [7:0] CTRL_IDX = 8'h03;

    typedef struct packed {
        logic alt;
        logic inv;
        logic dir_in;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RST = '{alt: 1'b0, inv: 1'b0, dir_in: 1'b1};

    typedef struct packed {
        logic       en;
        logic [1:0] sel;
    } ctrl_t;

    typedef struct packed {
        logic       hit;
        logic [1:0] grp;
        logic [2:0] pos;
    } cfg_loc_t;

    function automatic int grp_width(input int g);
        return (g == 1) ? 6 : GRP_W;
    endfunction

    function automatic logic [7:0] grp_cfg_base(input int g);
        case (g)
            0:       return 8'hE0;
            1:       return 8'hE8;
            default: return 8'hF5;
        endcase
    endfunction

    function automatic logic pin_exists(input int g, input int b);
        return b < grp_width(g);
    endfunction

    function automatic logic pin_has_alt(input int g, input int b);
        return !(g == 1 && b <= 4);
    endfunction

    function automatic logic [7:0] grp_mask(input int g);
        logic [7:0] m;
        m = '0;
        for (int b = 0; b < GRP_W; b++) m[b] = pin_exists(g, b);
        return m;
    endfunction

    function automatic cfg_loc_t cfg_locate(input logic [7:0] a);
        cfg_loc_t   r;
        logic [7:0] off;
        r = '0;
        for (int g = 0; g < GRP_N; g++) begin
            off = a - grp_cfg_base(g);
            if (a >= grp_cfg_base(g) && int'(off) < grp_width(g)) begin
                r.hit = 1'b1;
                r.grp = 2'(g);
                r.pos = off[2:0];
            end
        end
        return r;
    endfunction

    function automatic logic [7:0] pair_base(input logic [1:0] s);
        case (s)
            2'd0:    return 8'hE0;
            2'd1:    return 8'hE2;
            2'd2:    return 8'hE4;
            default: return 8'hEA;
        endcase
    endfunction

    function automatic logic [7:0] cfg_to_byte(input pin_cfg_t c);
        return {4'b0000, c.alt, 1'b0, c.inv, c.dir_in};
    endfunction

endpackage

// File: rtl/cio_cfg_regs.sv
module cio_cfg_regs
    import cio_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [7:0]             cfg_addr,
    input  logic [7:0]             cfg_wdata,
    output pin_cfg_t [PIN_N-1:0]   cfg_o,
    output ctrl_t                  ctrl_o,
    output logic [7:0]             cfg_rdata
);

    cfg_loc_t loc;
    ctrl_t    ctrl_q;

    assign loc = cfg_locate(cfg_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (cfg_we && cfg_addr == CTRL_IDX) begin
            ctrl_q.en  <= cfg_wdata[7];
            ctrl_q.sel <= cfg_wdata[1:0];
        end
    end

    assign ctrl_o = ctrl_q;

    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        for (genvar b = 0; b < GRP_W; b++) begin : g_bit
            localparam int IDX = g * GRP_W + b;
            if (pin_exists(g, b)) begin : g_live
                localparam logic ALT_OK = pin_has_alt(g, b);
                pin_cfg_t q;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        q <= CFG_RST;
                    end else if (cfg_we && loc.hit && loc.grp == 2'(g) && loc.pos == 3'(b)) begin
                        q.dir_in <= cfg_wdata[0];
                        q.inv    <= cfg_wdata[1];
                        q.alt    <= cfg_wdata[3] & ALT_OK;
                    end
                end
                assign cfg_o[IDX] = q;
            end else begin : g_none
                assign cfg_o[IDX] = CFG_RST;
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == CTRL_IDX)
            cfg_rdata = {ctrl_q.en, 5'b00000, ctrl_q.sel};
        else if (loc.hit)
            cfg_rdata = cfg_to_byte(cfg_o[{loc.grp, loc.pos}]);
    end

    logic unused_wbits;
    assign unused_wbits = ^{cfg_wdata[6:4], cfg_wdata[2]};

    logic [PIN_N-1:0] dir_vec;
    always_comb begin
        for (int i = 0; i < PIN_N; i++) dir_vec[i] = cfg_o[i].dir_in;
    end

    // R1: first cycle after reset shows a disabled pair and all-input pins
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ctrl_o.en && (&dir_vec)));

endmodule

// File: rtl/cio_data_port.sv
module cio_data_port
    import cio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl_i,
    input  logic [7:0]       io_addr,
    input  logic             io_wr,
    input  logic             io_rd,
    input  logic [7:0]       io_wdata,
    input  logic [PIN_N-1:0] view_i,
    output logic             io_hit,
    output logic [7:0]       io_rdata,
    output logic [PIN_N-1:0] data_o
);

    logic [7:0] base;
    logic [7:0] idx_q;
    logic       at_idx, at_dat, hit;
    logic       gsel_ok;
    logic [1:0] gsel;

    assign base    = pair_base(ctrl_i.sel);
    assign at_idx  = (io_addr == base);
    assign at_dat  = (io_addr == base + 8'd1);
    assign hit     = ctrl_i.en && (io_wr || io_rd) && (at_idx || at_dat);
    assign gsel_ok = (idx_q != 8'd0) && (idx_q <= 8'(GRP_N));
    assign gsel    = idx_q[1:0] - 2'd1;
    assign io_hit  = hit;

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (hit && io_wr && at_idx)
            idx_q <= io_wdata;
    end

    for (genvar g = 0; g < GRP_N; g++) begin : g_lat
        localparam logic [7:0] MASK = grp_mask(g);
        logic [GRP_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (hit && io_wr && at_dat && gsel_ok && gsel == 2'(g))
                q <= io_wdata & MASK;
        end
        assign data_o[g*GRP_W +: GRP_W] = q;
    end

    always_comb begin
        io_rdata = '0;
        if (hit && io_rd) begin
            if (at_idx)
                io_rdata = idx_q;
            else if (gsel_ok)
                io_rdata = view_i[gsel*GRP_W +: GRP_W];
        end
    end

    // R5: a disabled pair leaves latches and index untouched
    p_quiet_off_r5: assert property (@(posedge clk) disable iff (rst)
        !ctrl_i.en |=> ($stable(data_o) && $stable(idx_q)));

    // R6: an index write is visible on the next cycle
    p_index_load_r6: assert property (@(posedge clk) disable iff (rst)
        (hit && io_wr && at_idx) |=> (idx_q == $past(io_wdata)));

endmodule

// File: rtl/cio_pad_mux.sv
module cio_pad_mux
    import cio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  pin_cfg_t [PIN_N-1:0] cfg_i,
    input  logic [PIN_N-1:0]     data_i,
    input  logic [PIN_N-1:0]     pad_in,
    input  logic [PIN_N-1:0]     alt_out,
    input  logic [PIN_N-1:0]     alt_oe,
    output logic [PIN_N-1:0]     pad_out,
    output logic [PIN_N-1:0]     pad_oe,
    output logic [PIN_N-1:0]     view_o,
    output logic [PIN_N-1:0]     alt_in
);

    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        for (genvar b = 0; b < GRP_W; b++) begin : g_bit
            localparam int I = g * GRP_W + b;
            if (pin_exists(g, b)) begin : g_live
                pin_cfg_t c;
                assign c = cfg_i[I];

                assign pad_out[I] = c.alt ? alt_out[I] : (data_i[I] ^ c.inv);
                assign pad_oe[I]  = c.alt ? alt_oe[I]  : ~c.dir_in;
                assign view_o[I]  = (c.alt || c.dir_in) ? (pad_in[I] ^ c.inv) : data_i[I];
                assign alt_in[I]  = pad_in[I];

                // R9: quiet peripheral in alternate mode keeps the pad steady
                p_alt_holds_r9: assert property (@(posedge clk) disable iff (rst)
                    (c.alt && $stable(c) && $stable(alt_out[I]) && $stable(alt_oe[I]))
                    |-> ($stable(pad_out[I]) && $stable(pad_oe[I])));

                // R7: in GPIO output mode a latch change reaches the pad
                p_out_tracks_r7: assert property (@(posedge clk) disable iff (rst)
                    (!c.alt && !c.dir_in && $stable(c) && !$stable(data_i[I]))
                    |-> !$stable(pad_out[I]));
            end else begin : g_none
                assign pad_out[I] = 1'b0;
                assign pad_oe[I]  = 1'b0;
                assign view_o[I]  = 1'b0;
                assign alt_in[I]  = 1'b0;
                logic unused_pin;
                assign unused_pin = ^{alt_out[I], alt_oe[I], data_i[I], pad_in[I], cfg_i[I]};
            end
        end
    end

endmodule

// File: rtl/cio_unit.sv
module cio_unit
    import cio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_addr,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic [7:0]       io_addr,
    input  logic             io_wr,
    input  logic             io_rd,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    output logic             io_hit,
    input  logic [PIN_N-1:0] pad_in,
    output logic [PIN_N-1:0] pad_out,
    output logic [PIN_N-1:0] pad_oe,
    input  logic [PIN_N-1:0] alt_out,
    input  logic [PIN_N-1:0] alt_oe,
    output logic [PIN_N-1:0] alt_in
);

    pin_cfg_t [PIN_N-1:0] cfg_w;
    ctrl_t                ctrl_w;
    logic [PIN_N-1:0]     data_w;
    logic [PIN_N-1:0]     view_w;

    cio_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_o     (cfg_w),
        .ctrl_o    (ctrl_w),
        .cfg_rdata (cfg_rdata)
    );

    cio_data_port u_port (
        .clk      (clk),
        .rst      (rst),
        .ctrl_i   (ctrl_w),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_wdata (io_wdata),
        .view_i   (view_w),
        .io_hit   (io_hit),
        .io_rdata (io_rdata),
        .data_o   (data_w)
    );

    cio_pad_mux u_mux (
        .clk     (clk),
        .rst     (rst),
        .cfg_i   (cfg_w),
        .data_i  (data_w),
        .pad_in  (pad_in),
        .alt_out (alt_out),
        .alt_oe  (alt_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .view_o  (view_w),
        .alt_in  (alt_in)
    );

    // R10: dedicated pins 20-24 change direction only after a configuration write
    p_dedicated_r10: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(pad_oe[12:8]));

endmodule

// File: tb/cio_unit_test.sv
module cio_unit_test;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [7:0]  io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_hit;
    logic [23:0] pad_in = '0;
    logic [23:0] pad_out;
    logic [23:0] pad_oe;
    logic [23:0] alt_out = '0;
    logic [23:0] alt_oe = '0;
    logic [23:0] alt_in;

    int errors = 0;
    int checks = 0;

    always #(PERIOD/2) clk = ~clk;

    cio_unit uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_hit(io_hit), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in)
    );

    typedef struct packed {
        logic [7:0] caddr;
        logic [7:0] cval;
        logic [1:0] grp;
        logic [2:0] pos;
        logic [7:0] wdat;
        logic [7:0] pad;
        logic       aout;
        logic       aoe;
        logic [7:0] exp_rd;
        logic       exp_out;
        logic       exp_oe;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'hE0, 8'h00, 2'd1, 3'd0, 8'h01, 8'h00, 1'b0, 1'b0, 8'h01, 1'b1, 1'b1},
        '{8'hE3, 8'h02, 2'd1, 3'd3, 8'h08, 8'hF0, 1'b0, 1'b0, 8'hF8, 1'b0, 1'b1},
        '{8'hE7, 8'h03, 2'd1, 3'd7, 8'h00, 8'h80, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0},
        '{8'hEA, 8'h01, 2'd2, 3'd2, 8'hFF, 8'hFF, 1'b0, 1'b0, 8'h3F, 1'b1, 1'b0},
        '{8'hED, 8'h08, 2'd2, 3'd5, 8'h00, 8'h20, 1'b1, 1'b1, 8'h20, 1'b1, 1'b1},
        '{8'hF6, 8'h00, 2'd3, 3'd1, 8'h02, 8'h00, 1'b0, 1'b0, 8'h02, 1'b1, 1'b1},
        '{8'hFC, 8'h0A, 2'd3, 3'd7, 8'h80, 8'h80, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1},
        '{8'hFA, 8'h00, 2'd3, 3'd5, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h20, 1'b1, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [7:0] a, output logic [7:0] d, output logic h);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1;
        d = io_rdata; h = io_hit;
        io_rd = 1'b0;
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic       h;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1;
        check("R1 pad_oe after reset", 32'(pad_oe), 32'h0);
        cfg_read(8'h03, rd); check("R1 control byte after reset", 32'(rd), 32'h00);
        cfg_read(8'hE0, rd); check("R1 pin10 config after reset", 32'(rd), 32'h01);
        cfg_read(8'hFC, rd); check("R1 pin37 config after reset", 32'(rd), 32'h01);
        // R5 pair off after reset
        io_read(8'hE0, rd, h);
        check("R5 hit while disabled", 32'(h), 32'h0);
        check("R5 rdata while disabled", 32'(rd), 32'h0);

        // R2 stored bits only
        cfg_write(8'hE1, 8'hFF);
        cfg_read(8'hE1, rd); check("R2 config readback mask", 32'(rd), 32'h0B);
        cfg_write(8'hE1, 8'h01);

        // R3 holes in the map
        cfg_read(8'hEE, rd); check("R3 hole 0xEE reads 0", 32'(rd), 32'h0);
        cfg_read(8'hFD, rd); check("R3 hole 0xFD reads 0", 32'(rd), 32'h0);
        cfg_write(8'hF4, 8'h00);
        #1; check("R3 write to 0xF4 ignored", 32'(pad_oe), 32'h0);

        // R4 control byte and relocation
        cfg_write(8'h03, 8'hFE);
        cfg_read(8'h03, rd); check("R4 control readback", 32'(rd), 32'h82);
        io_read(8'hE4, rd, h); check("R4 index at 0xE4 hit", 32'(h), 32'h1);
        io_read(8'hEA, rd, h); check("R4 0xEA idle for sel 2", 32'(h), 32'h0);
        cfg_write(8'h03, 8'h83);
        cfg_read(8'h03, rd); check("R4 control readback sel 3", 32'(rd), 32'h83);
        io_read(8'hEB, rd, h); check("R4 data at 0xEB hit", 32'(h), 32'h1);

        // Table: R7 output, R8 read composition, R9 alternate, R3 address map
        for (int i = 0; i < NV; i++) begin
            int p;
            p = (int'(VECS[i].grp) - 1) * 8 + int'(VECS[i].pos);
            cfg_write(VECS[i].caddr, VECS[i].cval);
            io_write(8'hEA, {6'b0, VECS[i].grp});
            io_write(8'hEB, VECS[i].wdat);
            @(negedge clk);
            pad_in = '0;
            pad_in[(int'(VECS[i].grp) - 1) * 8 +: 8] = VECS[i].pad;
            alt_out = '0; alt_out[p] = VECS[i].aout;
            alt_oe  = '0; alt_oe[p]  = VECS[i].aoe;
            io_read(8'hEB, rd, h);
            check($sformatf("R8 vector %0d read", i), 32'(rd), 32'(VECS[i].exp_rd));
            check($sformatf("R7/R9 vector %0d pad_out", i), 32'(pad_out[p]), 32'(VECS[i].exp_out));
            check($sformatf("R3/R7 vector %0d pad_oe", i), 32'(pad_oe[p]), 32'(VECS[i].exp_oe));
            cfg_write(VECS[i].caddr, 8'h01);
            io_write(8'hEB, 8'h00);
        end
        pad_in = '0; alt_out = '0; alt_oe = '0;

        // R6 index readback and out-of-range index
        cfg_write(8'hE0, 8'h00);
        io_write(8'hEA, 8'h01);
        io_write(8'hEB, 8'h00);
        io_write(8'hEA, 8'h04);
        io_read(8'hEA, rd, h); check("R6 index readback", 32'(rd), 32'h04);
        io_read(8'hEB, rd, h); check("R6 index 4 reads 0", 32'(rd), 32'h0);
        io_write(8'hEB, 8'hFF);
        #1; check("R6 index 4 write ignored", 32'(pad_out[0]), 32'h0);

        // R5 writes ignored while disabled
        cfg_write(8'h03, 8'h03);
        io_write(8'hEA, 8'h01);
        io_write(8'hEB, 8'hFF);
        #1; check("R5 latch unchanged while off", 32'(pad_out[0]), 32'h0);
        io_read(8'hEB, rd, h); check("R5 no hit while off", 32'(h), 32'h0);
        cfg_write(8'h03, 8'h83);
        io_read(8'hEA, rd, h); check("R5 index unchanged while off", 32'(rd), 32'h04);
        cfg_write(8'hE0, 8'h01);

        // R10 dedicated pin ignores alternate select
        cfg_write(8'hE8, 8'h08);
        cfg_read(8'hE8, rd); check("R10 pin20 alt bit dropped", 32'(rd), 32'h00);
        @(negedge clk);
        alt_out[8] = 1'b1; alt_oe[8] = 1'b0;
        io_write(8'hEA, 8'h02);
        io_write(8'hEB, 8'h00);
        #1;
        check("R10 pin20 oe from GPIO", 32'(pad_oe[8]), 32'h1);
        check("R10 pin20 out from latch 0", 32'(pad_out[8]), 32'h0);
        io_write(8'hEB, 8'h01);
        #1; check("R10 pin20 out from latch 1", 32'(pad_out[8]), 32'h1);

        // R9 latch has no effect on alternate pin 25
        cfg_write(8'hED, 8'h08);
        @(negedge clk);
        alt_out[13] = 1'b0; alt_oe[13] = 1'b1;
        io_write(8'hEB, 8'h20);
        #1;
        check("R9 pin25 out ignores latch", 32'(pad_out[13]), 32'h0);
        check("R9 pin25 oe from peripheral", 32'(pad_oe[13]), 32'h1);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule